// File: doc/BRIEF.md
# Relocated-Line Directory with LRU Replacement

This block is the lookup structure a group-associative cache controller uses to find lines that sit outside their home slot. Each entry pairs a full block address with the index of the cache slot that currently holds that line. Any slot in the cache may be the target. While an address is held here, the target slot's own stored tag plays no part in the lookup for that address; the slot index from this directory is authoritative.

The directory is set-associative. The low bits of the block address select a set and the remaining bits form the stored tag. The lookup port is purely combinational so that it can run beside the primary tag compare in the same cycle. An insert takes a free way of its set when one exists. When every way of the set is valid, the insert replaces the least recently used way and reports that entry's slot on an eviction output one cycle later. The controller then marks that slot disposable, unless the slot is in its set-reference history. The controller also clears the disposable bit of every slot it inserts here. An invalidate port removes an entry when its line is swapped back to its home slot. Lookup hits and inserts both refresh the recency state.

Top module: `reloc_dir`

## Requirements
- R1: `lk_hit` and `lk_slot` are combinational. In the same cycle, `lk_hit` is 1 exactly when `lk_valid` is 1 and a valid entry in set `lk_addr[SET_W-1:0]` stores tag `lk_addr[ADDR_W-1:SET_W]`; `lk_slot` is then that entry's slot.
- R2: An insert of an absent address into a set with a free way stores the mapping and produces no eviction.
- R3: An insert of an absent address into a full set replaces the least recently used way. `ev_valid` is 1 for exactly the cycle after the insert edge, and `ev_slot` holds the replaced entry's slot.
- R4: A lookup hit and an insert each make the touched way the most recently used way of its set. When both touch the same set in one cycle, the insert is applied last.
- R5: An insert of an address that is already present rewrites that entry's slot in place, with no eviction.
- R6: An invalidate removes the matching entry. Later lookups of that address miss, and its way becomes free for the next insert.
- R7: An invalidate of an address that is not present changes nothing: other entries still hit with their slots and `ins_full` is unchanged.
- R8: `ins_full` is 1 exactly when every way of set `ins_addr[SET_W-1:0]` is valid, counting an invalidate in the same cycle as already applied.
- R9: After reset every entry is invalid, lookups miss and `ev_valid` is 0.
- R10: Sets are independent. The same tag in two sets gives two distinct mappings, and inserts into one set never evict from another.
- R11: When an invalidate and an insert arrive in the same cycle, the invalidate is applied first. An insert into a full set whose entry is being invalidated therefore takes the freed way without eviction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Block address to look up |
| lk_hit | output | 1 | Address is mapped (combinational) |
| lk_slot | output | SLOT_W | Cache slot holding the line (combinational) |
| ins_valid | input | 1 | Insert request |
| ins_addr | input | ADDR_W | Block address to map |
| ins_slot | input | SLOT_W | Cache slot that receives the line |
| ins_full | output | 1 | Set of `ins_addr` has no free way |
| inv_valid | input | 1 | Invalidate request |
| inv_addr | input | ADDR_W | Block address whose mapping is removed |
| ev_valid | output | 1 | An entry was evicted by the previous insert |
| ev_slot | output | SLOT_W | Slot of the evicted entry |

## Verification
The bench uses the defaults: 12-bit block addresses, 6-bit slots, and 4 sets of 2 ways. With only two ways, a set fills after two inserts, so every eviction path is reached within a few operations. The recency order can be steered with single lookups, which lets the bench pick the victim in advance. With four sets, the same tag can be placed in a neighbouring set to show that sets do not interact.

// File: rtl/reloc_dir_pkg.sv
package reloc_dir_pkg;

  localparam int unsigned DEF_ADDR_W = 12;
  localparam int unsigned DEF_SLOT_W = 6;
  localparam int unsigned DEF_SETS   = 4;
  localparam int unsigned DEF_WAYS   = 2;

  // Age of one way after some way with age 'pivot' is touched.
  // Age 0 is most recent. Ages of a set always form a permutation of 0..WAYS-1.
  function automatic int unsigned touch_age(input int unsigned cur,
                                            input int unsigned pivot,
                                            input bit          self);
    if (self)
      return 0;
    if (cur < pivot)
      return cur + 1;
    return cur;
  endfunction

endpackage

// File: rtl/reloc_dir_probe.sv
module reloc_dir_probe #(
  parameter int unsigned WAYS   = 2,
  parameter int unsigned TAG_W  = 10,
  parameter int unsigned SLOT_W = 6,
  parameter int unsigned WAY_W  = 1
) (
  input  logic [TAG_W-1:0]  key,
  input  logic [TAG_W-1:0]  row_tag  [WAYS],
  input  logic [SLOT_W-1:0] row_slot [WAYS],
  input  logic [WAYS-1:0]   row_vld,
  output logic [WAYS-1:0]   hit_vec,
  output logic              hit,
  output logic [WAY_W-1:0]  hit_way,
  output logic [SLOT_W-1:0] hit_slot
);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = row_vld[w] && (row_tag[w] == key);
  end

  always_comb begin
    hit      = 1'b0;
    hit_way  = '0;
    hit_slot = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w] && !hit) begin
        hit      = 1'b1;
        hit_way  = WAY_W'(w);
        hit_slot = row_slot[w];
      end
    end
  end

endmodule

// File: rtl/reloc_dir_age.sv
module reloc_dir_age
  import reloc_dir_pkg::*;
#(
  parameter int unsigned SETS  = 4,
  parameter int unsigned WAYS  = 2,
  parameter int unsigned SET_W = 2,
  parameter int unsigned WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_en,
  input  logic [SET_W-1:0] a_set,
  input  logic [WAY_W-1:0] a_way,
  input  logic             b_en,
  input  logic [SET_W-1:0] b_set,
  input  logic [WAY_W-1:0] b_way,
  input  logic [SET_W-1:0] q_set,
  output logic [WAY_W-1:0] victim
);

  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAY_W-1:0] age_n [SETS][WAYS];
  logic [WAY_W-1:0] piv_a, piv_b;

  always_comb begin
    age_n = age_q;
    piv_a = age_q[a_set][a_way];
    if (a_en) begin
      for (int w = 0; w < WAYS; w++)
        age_n[a_set][w] = WAY_W'(touch_age(int'(age_q[a_set][w]), int'(piv_a),
                                           w == int'(a_way)));
    end
    piv_b = age_n[b_set][b_way];
    if (b_en) begin
      for (int w = 0; w < WAYS; w++)
        age_n[b_set][w] = WAY_W'(touch_age(int'(age_n[b_set][w]), int'(piv_b),
                                           w == int'(b_way)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else begin
      age_q <= age_n;
    end
  end

  always_comb begin
    victim = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[q_set][w] == WAY_W'(WAYS - 1))
        victim = WAY_W'(w);
  end

endmodule

// File: rtl/reloc_dir.sv
module reloc_dir
  import reloc_dir_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned SLOT_W = DEF_SLOT_W,
  parameter int unsigned SETS   = DEF_SETS,
  parameter int unsigned WAYS   = DEF_WAYS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [SLOT_W-1:0] lk_slot,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [SLOT_W-1:0] ins_slot,
  output logic              ins_full,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              ev_valid,
  output logic [SLOT_W-1:0] ev_slot
);

  localparam int unsigned SET_W = $clog2(SETS);
  localparam int unsigned TAG_W = ADDR_W - SET_W;
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int unsigned NPRB  = 3;
  localparam int unsigned P_LK  = 0;
  localparam int unsigned P_INS = 1;
  localparam int unsigned P_INV = 2;

  function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[SET_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:SET_W];
  endfunction

  function automatic logic [WAY_W-1:0] low_free(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!v[w]) r = WAY_W'(w);
    return r;
  endfunction

  // storage
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [SLOT_W-1:0] slot_q [SETS][WAYS];
  logic [WAYS-1:0]   vld_q  [SETS];
  logic [WAYS-1:0]   vld_n  [SETS];

  // probe fabric: lookup, insert, invalidate
  logic [SET_W-1:0]  pr_set  [NPRB];
  logic [TAG_W-1:0]  pr_key  [NPRB];
  logic [TAG_W-1:0]  pr_tag  [NPRB][WAYS];
  logic [SLOT_W-1:0] pr_slot [NPRB][WAYS];
  logic [WAYS-1:0]   pr_vld  [NPRB];
  logic [WAYS-1:0]   pr_vec  [NPRB];
  logic              pr_hit  [NPRB];
  logic [WAY_W-1:0]  pr_way  [NPRB];
  logic [SLOT_W-1:0] pr_out  [NPRB];

  assign pr_set[P_LK]  = set_of(lk_addr);
  assign pr_set[P_INS] = set_of(ins_addr);
  assign pr_set[P_INV] = set_of(inv_addr);
  assign pr_key[P_LK]  = tag_of(lk_addr);
  assign pr_key[P_INS] = tag_of(ins_addr);
  assign pr_key[P_INV] = tag_of(inv_addr);

  always_comb begin
    for (int p = 0; p < NPRB; p++)
      for (int w = 0; w < WAYS; w++) begin
        pr_tag[p][w]  = tag_q[pr_set[p]][w];
        pr_slot[p][w] = slot_q[pr_set[p]][w];
      end
  end

  // named internal events
  logic             inv_fire;
  logic [WAYS-1:0]  ins_row_vld;
  logic             ins_hit;
  logic             ins_evict;
  logic [WAY_W-1:0] ins_way;
  logic [WAY_W-1:0] lru_way;

  assign inv_fire = inv_valid && pr_hit[P_INV];

  // the insert sees its set with a same-cycle invalidation already applied
  assign ins_row_vld = vld_q[pr_set[P_INS]] &
                       ~((inv_fire && (pr_set[P_INV] == pr_set[P_INS])) ? pr_vec[P_INV]
                                                                         : '0);
  assign pr_vld[P_LK]  = vld_q[pr_set[P_LK]];
  assign pr_vld[P_INS] = ins_row_vld;
  assign pr_vld[P_INV] = vld_q[pr_set[P_INV]];

  for (genvar p = 0; p < NPRB; p++) begin : g_prb
    reloc_dir_probe #(
      .WAYS(WAYS), .TAG_W(TAG_W), .SLOT_W(SLOT_W), .WAY_W(WAY_W)
    ) u_prb (
      .key      (pr_key[p]),
      .row_tag  (pr_tag[p]),
      .row_slot (pr_slot[p]),
      .row_vld  (pr_vld[p]),
      .hit_vec  (pr_vec[p]),
      .hit      (pr_hit[p]),
      .hit_way  (pr_way[p]),
      .hit_slot (pr_out[p])
    );
  end

  assign lk_hit   = lk_valid && pr_hit[P_LK];
  assign lk_slot  = pr_out[P_LK];
  assign ins_full = &ins_row_vld;
  assign ins_hit  = pr_hit[P_INS];
  assign ins_evict = ins_valid && !ins_hit && ins_full;

  always_comb begin
    if (ins_hit)       ins_way = pr_way[P_INS];
    else if (ins_full) ins_way = lru_way;
    else               ins_way = low_free(ins_row_vld);
  end

  reloc_dir_age #(
    .SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)
  ) u_age (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_en   (lk_hit),
    .a_set  (pr_set[P_LK]),
    .a_way  (pr_way[P_LK]),
    .b_en   (ins_valid),
    .b_set  (pr_set[P_INS]),
    .b_way  (ins_way),
    .q_set  (pr_set[P_INS]),
    .victim (lru_way)
  );

  always_comb begin
    vld_n = vld_q;
    if (inv_fire)
      vld_n[pr_set[P_INV]][pr_way[P_INV]] = 1'b0;
    if (ins_valid)
      vld_n[pr_set[P_INS]][ins_way] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        vld_q[s] <= '0;
      ev_valid <= 1'b0;
      ev_slot  <= '0;
    end else begin
      vld_q    <= vld_n;
      ev_valid <= ins_evict;
      ev_slot  <= slot_q[pr_set[P_INS]][lru_way];
    end
  end

  always_ff @(posedge clk) begin
    if (ins_valid) begin
      tag_q[pr_set[P_INS]][ins_way]  <= pr_key[P_INS];
      slot_q[pr_set[P_INS]][ins_way] <= ins_slot;
    end
  end

endmodule

// File: rtl/reloc_dir_chk.sv
module reloc_dir_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned SLOT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              lk_hit,
  input logic [SLOT_W-1:0] lk_slot,
  input logic              ins_valid,
  input logic [ADDR_W-1:0] ins_addr,
  input logic [SLOT_W-1:0] ins_slot,
  input logic              ins_full,
  input logic              inv_valid,
  input logic [ADDR_W-1:0] inv_addr,
  input logic              ev_valid,
  input logic              ins_evict
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_LK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !lk_hit); // R1

  AST_EV_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ev_valid) |-> $past(ins_valid && ins_full)); // R3

  AST_NO_EV_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(ins_valid && !ins_full)) |-> !ev_valid); // R2

  AST_INS_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(ins_valid) && lk_valid && lk_addr == $past(ins_addr))
      |-> (lk_hit && lk_slot == $past(ins_slot))); // R5

  AST_INV_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(inv_valid && !(ins_valid && ins_addr == inv_addr)) &&
     lk_valid && lk_addr == $past(inv_addr)) |-> !lk_hit); // R6

  AST_EVICT_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_evict && lk_valid && lk_addr == ins_addr) |-> !lk_hit); // R5

endmodule

bind reloc_dir reloc_dir_chk #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_valid  (lk_valid),
  .lk_addr   (lk_addr),
  .lk_hit    (lk_hit),
  .lk_slot   (lk_slot),
  .ins_valid (ins_valid),
  .ins_addr  (ins_addr),
  .ins_slot  (ins_slot),
  .ins_full  (ins_full),
  .inv_valid (inv_valid),
  .inv_addr  (inv_addr),
  .ev_valid  (ev_valid),
  .ins_evict (ins_evict)
);

// File: tb/tb_reloc_dir.sv
module tb_reloc_dir;

  localparam int CLK_NS = 10;
  localparam int ADDR_W = 12;
  localparam int SLOT_W = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              lk_valid = 1'b0;
  logic [ADDR_W-1:0] lk_addr = '0;
  logic              lk_hit;
  logic [SLOT_W-1:0] lk_slot;
  logic              ins_valid = 1'b0;
  logic [ADDR_W-1:0] ins_addr = '0;
  logic [SLOT_W-1:0] ins_slot = '0;
  logic              ins_full;
  logic              inv_valid = 1'b0;
  logic [ADDR_W-1:0] inv_addr = '0;
  logic              ev_valid;
  logic [SLOT_W-1:0] ev_slot;

  reloc_dir dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_slot(lk_slot),
    .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_slot(ins_slot), .ins_full(ins_full),
    .inv_valid(inv_valid), .inv_addr(inv_addr),
    .ev_valid(ev_valid), .ev_slot(ev_slot)
  );

  always #(CLK_NS / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int exp_q[$];

  // block address = tag * 4 + set (2 set-index bits with 4 sets)
  function automatic logic [ADDR_W-1:0] mk(input int tag, input int set);
    return ADDR_W'(tag * 4 + set);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic look(input logic [ADDR_W-1:0] a, input bit ehit, input int eslot,
                      input string req);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_addr  = a;
    #1;
    chk(lk_hit == ehit, req, "lookup hit", int'(lk_hit), int'(ehit));
    if (ehit)
      chk(int'(lk_slot) == eslot, req, "lookup slot", int'(lk_slot), eslot);
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  // driver: pushes the expected eviction onto the scoreboard
  task automatic put(input logic [ADDR_W-1:0] a, input int s, input bit evict,
                     input int evs);
    @(negedge clk);
    ins_valid = 1'b1;
    ins_addr  = a;
    ins_slot  = SLOT_W'(s);
    if (evict) exp_q.push_back(evs);
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  task automatic drop(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    inv_valid = 1'b1;
    inv_addr  = a;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  task automatic full_is(input logic [ADDR_W-1:0] a, input bit e, input string req);
    @(negedge clk);
    ins_addr = a;
    #1;
    chk(ins_full == e, req, "ins_full", int'(ins_full), int'(e));
  endtask

  // monitor: every eviction pulse must match the next expected slot
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && ev_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 R3", "unexpected eviction slot", int'(ev_slot), -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(ev_slot) == e, "R3", "evicted slot", int'(ev_slot), e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog run did not finish actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state
    #1;
    chk(ev_valid == 1'b0, "R9", "ev_valid after reset", int'(ev_valid), 0);
    look(mk(0, 0), 1'b0, 0, "R9");
    full_is(mk(1, 0), 1'b0, "R9");

    // R2: fill set 0 through free ways
    put(mk(1, 0), 5, 1'b0, 0);   // A
    put(mk(2, 0), 9, 1'b0, 0);   // B
    look(mk(1, 0), 1'b1, 5, "R1");
    look(mk(2, 0), 1'b1, 9, "R2");
    @(negedge clk);
    lk_valid = 1'b0;
    lk_addr  = mk(1, 0);
    #1;
    chk(lk_hit == 1'b0, "R1", "hit without lk_valid", int'(lk_hit), 0);
    full_is(mk(3, 0), 1'b1, "R8");
    full_is(mk(3, 1), 1'b0, "R8");

    // R4: touch A, so B is least recent and gets evicted
    look(mk(1, 0), 1'b1, 5, "R4");
    put(mk(3, 0), 12, 1'b1, 9);  // C evicts B
    look(mk(2, 0), 1'b0, 0, "R3");
    look(mk(1, 0), 1'b1, 5, "R4");
    look(mk(3, 0), 1'b1, 12, "R4");
    put(mk(4, 0), 20, 1'b1, 5);  // D evicts A

    // R5: rewrite D in place
    put(mk(4, 0), 33, 1'b0, 0);
    look(mk(4, 0), 1'b1, 33, "R5");
    look(mk(3, 0), 1'b1, 12, "R5");

    // R6: invalidate C frees its way
    drop(mk(3, 0));
    look(mk(3, 0), 1'b0, 0, "R6");
    full_is(mk(5, 0), 1'b0, "R6");
    put(mk(5, 0), 40, 1'b0, 0);  // E
    look(mk(5, 0), 1'b1, 40, "R6");

    // R7: invalidate of an absent address
    drop(mk(9, 0));
    look(mk(4, 0), 1'b1, 33, "R7");
    look(mk(5, 0), 1'b1, 40, "R7");
    full_is(mk(6, 0), 1'b1, "R7");

    // R10: same tag in set 1
    put(mk(4, 1), 7, 1'b0, 0);
    look(mk(4, 1), 1'b1, 7, "R10");
    look(mk(4, 0), 1'b1, 33, "R10");   // D most recent, E least recent

    // R11: invalidate D and insert F together in a full set
    @(negedge clk);
    inv_valid = 1'b1;
    inv_addr  = mk(4, 0);
    ins_valid = 1'b1;
    ins_addr  = mk(6, 0);
    ins_slot  = SLOT_W'(50);
    #1;
    chk(ins_full == 1'b0, "R11", "ins_full with same-cycle invalidate", int'(ins_full), 0);
    @(negedge clk);
    inv_valid = 1'b0;
    ins_valid = 1'b0;
    look(mk(4, 0), 1'b0, 0, "R11");
    look(mk(5, 0), 1'b1, 40, "R11");
    look(mk(6, 0), 1'b1, 50, "R11");
    put(mk(7, 0), 60, 1'b1, 40);   // E least recent
    look(mk(7, 0), 1'b1, 60, "R3");
    look(mk(4, 1), 1'b1, 7, "R10");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "evictions still pending", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule